// File: doc/BRIEF.md
# Variable-Length Three-Wire Control Word Receiver

The block takes control words from a three-wire serial link (enable, serial clock, serial data) and spreads their fields over three parallel register groups: a four-bit band-switch port register, a fifteen-bit divider word and a small control group. The control group holds test bits, a charge-pump current bit, two ratio-select bits and a tuning-amplifier bit.

A word may be 18, 19 or 27 bits long. Its length decides when each register group is written and which bits are forced rather than taken from the line. The three serial lines are treated as slow signals sampled by a fast system clock. The block finds the edges of the enable and serial clock lines itself.

After power-on every register holds a defined default. A flag drives the tuning-output enable once the first valid word has been committed. Words of a length that is not allowed raise a one-cycle error pulse.

Top module: `tw_word_rx`

## Requirements
- R1: A bit is taken from the data line only on a falling edge of the serial clock while enable is high. Serial clock activity while enable is low changes no output.
- R2: Bits arrive first-to-last from word MSB down. The first four bits, in arrival order, go to `port_o[3:0]`, with the first bit in `port_o[3]`. They are written on the 5th rising serial clock edge of the frame, and `port_o` changes at no other time.
- R3: For a 19-bit word, bits 5 to 19 (N14 first) are written to `div_o` when enable falls. For an 18-bit word, bits 5 to 18 go to `div_o[13:0]` and `div_o[14]` is forced to 0.
- R4: In a frame of 20 bits or more, bits 5 to 19 are written to `div_o` on the 20th rising serial clock edge, before enable falls.
- R5: An 18-bit word forces `rsa_o` to 1 and a 19-bit word forces it to 0.
- R6: A 27-bit word loads the control group when enable falls. Its last eight bits are, in arrival order: CP, T2, T1, T0, RSA, RSB, OS, and one spare bit that is ignored.
- R7: `test_o`, `cp_o`, `rsb_o` and `os_o` change only on a 27-bit word, with one exception given in R10. They keep their values through 18-bit and 19-bit words.
- R8: A frame shorter than 18 bits leaves `div_o` and the control group unchanged. Such a frame of 5 to 17 bits still updates `port_o` per R2.
- R9: After reset: `port_o` = 0, `div_o` = 0, `test_o` = 3'b001, `cp_o` = 1, `rsa_o` = 0, `rsb_o` = 1, `os_o` = 1, `tune_en_o` = 0, `len_err_o` = 0.
- R10: The first 18-bit or 19-bit word after reset clears `os_o` to 0, provided no valid word has been committed before it.
- R11: When enable falls on a frame of 20 bits or more whose length is not 27, `len_err_o` pulses high for exactly one cycle. The control group and `tune_en_o` are not written. The bit counter saturates at 31, so longer frames are also errors.
- R12: `tune_en_o` rises when the first 18-, 19- or 27-bit word is committed and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, samples the serial lines |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| en_i | input | 1 | Serial enable; high frames a word |
| sclk_i | input | 1 | Serial clock |
| sdata_i | input | 1 | Serial data |
| port_o | output | 4 | Band-switch port bits |
| div_o | output | 15 | Divider word N14..N0 |
| test_o | output | 3 | Test bits T2..T0 |
| cp_o | output | 1 | Charge-pump current select |
| rsa_o | output | 1 | Ratio select A |
| rsb_o | output | 1 | Ratio select B |
| os_o | output | 1 | Tuning-amplifier control |
| tune_en_o | output | 1 | Tuning-output enable |
| len_err_o | output | 1 | One-cycle pulse on an illegal word length |

## Verification
The bench builds the block with its default parameters: a four-bit port field, a fifteen-bit divider and a five-bit bit counter. With these values the legal lengths sit at 18, 19 and 27, and a 34-bit frame drives the counter into saturation at 31. Random frames of 3 to 34 bits therefore cover every commit point: the 5th and 20th rising edges, enable fall on legal and illegal lengths, and frames cut off before the port bits. Directed frames check the port and divider registers in the middle of a frame, just before and just after their commit edges.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int LEN_S18 = 18;
  localparam int LEN_S19 = 19;
  localparam int LEN_L27 = 27;

  typedef enum logic [2:0] {
    FK_NONE,
    FK_S18,
    FK_S19,
    FK_L27,
    FK_BAD
  } frame_kind_e;

  typedef struct packed {
    logic       cp;
    logic [2:0] test;
    logic       rsa;
    logic       rsb;
    logic       os;
  } ctl_t;

  function automatic frame_kind_e classify(input int unsigned len);
    if (len == LEN_S18)      return FK_S18;
    else if (len == LEN_S19) return FK_S19;
    else if (len == LEN_L27) return FK_L27;
    else if (len > LEN_S19)  return FK_BAD;
    else                     return FK_NONE;
  endfunction
endpackage

// File: rtl/tw_edge_sync.sv
module tw_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sclk_i,
  input  logic sdata_i,
  output logic en_o,
  output logic dat_o,
  output logic en_rise_o,
  output logic en_fall_o,
  output logic sclk_rise_o,
  output logic sclk_fall_o
);
  logic s_en, s_clk, s_dat, p_en, p_clk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_en  <= 1'b0;
      s_clk <= 1'b0;
      s_dat <= 1'b0;
      p_en  <= 1'b0;
      p_clk <= 1'b0;
    end else begin
      s_en  <= en_i;
      s_clk <= sclk_i;
      s_dat <= sdata_i;
      p_en  <= s_en;
      p_clk <= s_clk;
    end
  end

  assign en_o        = s_en;
  assign dat_o       = s_dat;
  assign en_rise_o   = s_en & ~p_en;
  assign en_fall_o   = ~s_en & p_en;
  assign sclk_rise_o = s_clk & ~p_clk;
  assign sclk_fall_o = ~s_clk & p_clk;
endmodule

// File: rtl/tw_shift_ctr.sv
module tw_shift_ctr #(
  parameter int SHIFT_W = 15,
  parameter int CNT_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               dat_i,
  input  logic               en_rise_i,
  input  logic               sclk_rise_i,
  input  logic               sclk_fall_i,
  output logic [SHIFT_W-1:0] shreg_o,
  output logic [CNT_W-1:0]   bit_cnt_o,
  output logic [CNT_W-1:0]   rise_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_o    <= '0;
      bit_cnt_o  <= '0;
      rise_cnt_o <= '0;
    end else if (en_rise_i) begin
      bit_cnt_o  <= '0;
      rise_cnt_o <= '0;
    end else if (en_i) begin
      if (sclk_fall_i) begin
        shreg_o <= {shreg_o[SHIFT_W-2:0], dat_i};
        if (bit_cnt_o != CNT_MAX) bit_cnt_o <= bit_cnt_o + 1'b1;
      end
      if (sclk_rise_i && rise_cnt_o != CNT_MAX) rise_cnt_o <= rise_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank
  import tw_pkg::*;
#(
  parameter int PORT_W = 4,
  parameter int DIV_W  = 15,
  parameter int CNT_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             port_load_i,
  input  logic             freq_load_i,
  input  logic             en_fall_i,
  input  logic [CNT_W-1:0] frame_len_i,
  input  logic [DIV_W-1:0] shreg_i,
  output logic [PORT_W-1:0] port_o,
  output logic [DIV_W-1:0] div_o,
  output ctl_t             ctl_o,
  output logic             tune_en_o,
  output logic             len_err_o
);
  localparam ctl_t CTL_RST = '{cp: 1'b1, test: 3'b001, rsa: 1'b0, rsb: 1'b1, os: 1'b1};

  frame_kind_e kind;
  assign kind = classify(32'(frame_len_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_o    <= '0;
      div_o     <= '0;
      ctl_o     <= CTL_RST;
      tune_en_o <= 1'b0;
      len_err_o <= 1'b0;
    end else begin
      len_err_o <= 1'b0;
      if (port_load_i) port_o <= shreg_i[PORT_W-1:0];
      if (freq_load_i) div_o <= shreg_i;
      if (en_fall_i) begin
        unique case (kind)
          FK_S18: begin
            div_o     <= {1'b0, shreg_i[DIV_W-2:0]};
            ctl_o.rsa <= 1'b1;
            if (!tune_en_o) ctl_o.os <= 1'b0;
            tune_en_o <= 1'b1;
          end
          FK_S19: begin
            div_o     <= shreg_i;
            ctl_o.rsa <= 1'b0;
            if (!tune_en_o) ctl_o.os <= 1'b0;
            tune_en_o <= 1'b1;
          end
          FK_L27: begin
            // last byte: cp t2 t1 t0 rsa rsb os spare
            ctl_o.cp   <= shreg_i[7];
            ctl_o.test <= shreg_i[6:4];
            ctl_o.rsa  <= shreg_i[3];
            ctl_o.rsb  <= shreg_i[2];
            ctl_o.os   <= shreg_i[1];
            tune_en_o  <= 1'b1;
          end
          FK_BAD:  len_err_o <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tw_word_rx.sv
module tw_word_rx
  import tw_pkg::*;
#(
  parameter int PORT_W = 4,
  parameter int DIV_W  = 15,
  parameter int CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic [PORT_W-1:0] port_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [2:0]        test_o,
  output logic              cp_o,
  output logic              rsa_o,
  output logic              rsb_o,
  output logic              os_o,
  output logic              tune_en_o,
  output logic              len_err_o
);
  localparam logic [CNT_W-1:0] PORT_AT = CNT_W'(PORT_W);
  localparam logic [CNT_W-1:0] FREQ_AT = CNT_W'(PORT_W + DIV_W);

  logic en_s, dat_s, en_rise, en_fall, sclk_rise, sclk_fall;
  logic [DIV_W-1:0] shreg;
  logic [CNT_W-1:0] bit_cnt, rise_cnt;
  logic port_load, freq_load;
  ctl_t ctl;

  tw_edge_sync u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sclk_i(sclk_i), .sdata_i(sdata_i),
    .en_o(en_s), .dat_o(dat_s), .en_rise_o(en_rise), .en_fall_o(en_fall),
    .sclk_rise_o(sclk_rise), .sclk_fall_o(sclk_fall)
  );

  tw_shift_ctr #(.SHIFT_W(DIV_W), .CNT_W(CNT_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_s), .dat_i(dat_s), .en_rise_i(en_rise),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .shreg_o(shreg), .bit_cnt_o(bit_cnt), .rise_cnt_o(rise_cnt)
  );

  // rising edge N+1 follows N sampled bits
  assign port_load = en_s & sclk_rise & (rise_cnt == PORT_AT) & (bit_cnt == PORT_AT);
  assign freq_load = en_s & sclk_rise & (rise_cnt == FREQ_AT) & (bit_cnt == FREQ_AT);

  tw_reg_bank #(.PORT_W(PORT_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .port_load_i(port_load), .freq_load_i(freq_load),
    .en_fall_i(en_fall), .frame_len_i(bit_cnt), .shreg_i(shreg),
    .port_o(port_o), .div_o(div_o), .ctl_o(ctl), .tune_en_o(tune_en_o), .len_err_o(len_err_o)
  );

  assign test_o = ctl.test;
  assign cp_o   = ctl.cp;
  assign rsa_o  = ctl.rsa;
  assign rsb_o  = ctl.rsb;
  assign os_o   = ctl.os;
endmodule

// File: rtl/tw_word_rx_chk.sv
module tw_word_rx_chk #(
  parameter int PORT_W = 4,
  parameter int DIV_W  = 15,
  parameter int CNT_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PORT_W-1:0] port_o,
  input logic [DIV_W-1:0]  div_o,
  input logic [2:0]        test_o,
  input logic              cp_o,
  input logic              rsa_o,
  input logic              rsb_o,
  input logic              tune_en_o,
  input logic              len_err_o,
  input logic              port_load,
  input logic              freq_load,
  input logic              en_fall,
  input logic [CNT_W-1:0]  bit_cnt
);
  logic commit18, commit19, commit27;
  assign commit18 = en_fall && (bit_cnt == CNT_W'(18));
  assign commit19 = en_fall && (bit_cnt == CNT_W'(19));
  assign commit27 = en_fall && (bit_cnt == CNT_W'(27));

  assert_port_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(port_o) |-> $past(port_load));

  assert_n14_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(commit18) |-> (div_o[DIV_W-1] == 1'b0));

  assert_rsa_forced_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(commit18 || commit19) |-> (rsa_o == $past(commit18)));

  assert_ctl_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({test_o, cp_o, rsb_o}) |-> $past(commit27));

  assert_div_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div_o) |-> $past(freq_load || commit18 || commit19));

  assert_err_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_err_o |=> !len_err_o);

  assert_tune_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(tune_en_o));
endmodule

bind tw_word_rx tw_word_rx_chk #(.PORT_W(PORT_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .port_o(port_o), .div_o(div_o), .test_o(test_o),
  .cp_o(cp_o), .rsa_o(rsa_o), .rsb_o(rsb_o), .tune_en_o(tune_en_o), .len_err_o(len_err_o),
  .port_load(port_load), .freq_load(freq_load), .en_fall(en_fall), .bit_cnt(bit_cnt)
);

// File: tb/tb_tw_word_rx.sv
module tb_tw_word_rx;
  localparam int H = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, sclk = 1'b0, sdata = 1'b0;
  logic [3:0]  port_o;
  logic [14:0] div_o;
  logic [2:0]  test_o;
  logic cp_o, rsa_o, rsb_o, os_o, tune_en_o, len_err_o;

  int checks = 0, errors = 0, err_seen = 0;

  logic [3:0]  e_port;
  logic [14:0] e_div;
  logic [2:0]  e_test;
  logic e_cp, e_rsa, e_rsb, e_os, e_tune;
  int   e_err;

  always #4 clk = ~clk;

  tw_word_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sclk_i(sclk), .sdata_i(sdata),
    .port_o(port_o), .div_o(div_o), .test_o(test_o), .cp_o(cp_o), .rsa_o(rsa_o),
    .rsb_o(rsb_o), .os_o(os_o), .tune_en_o(tune_en_o), .len_err_o(len_err_o)
  );

  always @(negedge clk) if (rst_n && len_err_o) err_seen++;

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [27:0] exp_vec();
    return {e_port, e_div, e_test, e_cp, e_rsa, e_rsb, e_os, e_tune};
  endfunction

  function automatic logic [27:0] act_vec();
    return {port_o, div_o, test_o, cp_o, rsa_o, rsb_o, os_o, tune_en_o};
  endfunction

  task automatic check_all(input string req);
    chk(act_vec() === exp_vec(), req, 32'(act_vec()), 32'(exp_vec()));
    chk(err_seen == e_err, {req, " R11 err count"}, err_seen, e_err);
  endtask

  // reference model of one complete frame, word bit len-1 sent first
  task automatic model(input int len, input logic [39:0] w);
    if (len >= 5) e_port = w[len-1 -: 4];
    if (len >= 20) e_div = w[len-5 -: 15];
    if (len == 18) begin
      e_div = {1'b0, w[13:0]}; e_rsa = 1'b1;
      if (!e_tune) e_os = 1'b0;
      e_tune = 1'b1;
    end else if (len == 19) begin
      e_div = w[14:0]; e_rsa = 1'b0;
      if (!e_tune) e_os = 1'b0;
      e_tune = 1'b1;
    end else if (len == 27) begin
      e_cp = w[7]; e_test = w[6:4]; e_rsa = w[3]; e_rsb = w[2]; e_os = w[1];
      e_tune = 1'b1;
    end else if (len >= 20) e_err++;
  endtask

  task automatic pulse(input logic b);
    sdata = b; sclk = 1'b1; wait_n(H);
    sclk = 1'b0; wait_n(H);
  endtask

  task automatic send_frame(input int len, input logic [39:0] w);
    en = 1'b1; wait_n(H);
    for (int i = len - 1; i >= 0; i--) pulse(w[i]);
    wait_n(H); en = 1'b0; wait_n(4);
    model(len, w);
  endtask

  function automatic string req_of(input int len);
    if (len == 18) return "R3 R5 R7 R10 R12 len18";
    if (len == 19) return "R3 R5 R7 R10 R12 len19";
    if (len == 27) return "R4 R6 R12 len27";
    if (len >= 20) return "R4 R11 badlen";
    return "R2 R8 short";
  endfunction

  initial begin
    logic [39:0] w;
    int lens[12] = '{3, 5, 12, 17, 18, 19, 19, 27, 27, 22, 30, 34};
    void'($urandom(32'h00C0FFEE));
    e_port = '0; e_div = '0; e_test = 3'b001; e_cp = 1'b1; e_rsa = 1'b0;
    e_rsb = 1'b1; e_os = 1'b1; e_tune = 1'b0; e_err = 0;
    wait_n(5); rst_n = 1'b1; wait_n(3);
    check_all("R9 reset");
    chk(len_err_o == 1'b0, "R9 reset err", len_err_o, 0);

    // R1: serial clock while enable low
    for (int i = 0; i < 10; i++) pulse(1'b1);
    wait_n(4);
    check_all("R1 idle clocks");

    // R2: port written exactly at 5th rising edge
    en = 1'b1; wait_n(H);
    pulse(1'b1); pulse(1'b0); pulse(1'b1); pulse(1'b0);
    chk(port_o == e_port, "R2 before 5th edge", port_o, e_port);
    sdata = 1'b0; sclk = 1'b1; wait_n(H);
    chk(port_o == 4'b1010, "R2 at 5th edge", port_o, 4'b1010);
    sclk = 1'b0; wait_n(H); wait_n(H);
    en = 1'b0; wait_n(4);
    model(5, 40'b10100);
    check_all("R2 R8 5-bit frame");

    // R10 R3 R5: first short word, N14 forced low
    send_frame(18, 40'h3_FFFF);
    check_all("R3 R5 R10 first len18");

    // R4: divider mid-frame at 20th rising edge of a 27-bit word
    w = 40'h5_A5C3_6E;
    en = 1'b1; wait_n(H);
    for (int i = 0; i < 19; i++) pulse(w[26-i]);
    chk(div_o == e_div, "R4 before 20th edge", div_o, e_div);
    sdata = w[7]; sclk = 1'b1; wait_n(H);
    chk(div_o == w[22:8], "R4 at 20th edge", div_o, w[22:8]);
    sclk = 1'b0; wait_n(H);
    for (int i = 20; i < 27; i++) pulse(w[26-i]);
    wait_n(H); en = 1'b0; wait_n(4);
    model(27, w);
    check_all("R4 R6 len27");

    // R7: 19-bit word keeps control group, forces RSA low
    send_frame(19, 40'h7_1234);
    check_all("R5 R7 len19 after len27");

    // R11: illegal length
    send_frame(22, 40'h3F_FFFF);
    check_all("R11 len22");

    // R8: 17-bit word leaves divider
    send_frame(17, 40'h0_0000);
    check_all("R8 len17");

    for (int n = 0; n < 150; n++) begin
      int len;
      len = lens[$urandom_range(0, 11)];
      w = {$urandom(), $urandom()};
      send_frame(len, w);
      check_all(req_of(len));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule